// File: doc/BRIEF.md
# Reference Impairment Monitor with Holdover

This block watches a reference clock against a fast local system clock. It counts reference rising edges over fixed measurement windows and judges each window. A window is impaired if its count falls outside a programmable acceptance band, if its count jumps too far from the previous window, or if the reference stops toggling. An impairment moves the block into Holdover. In Holdover the reported frequency word is frozen at an average of older measurements, so the output does not follow the disturbance that caused the impairment.

A small circular history keeps the most recent window counts. On entry to Holdover the frozen word is the floor of the mean of the windows aged 3, 4 and 5. The window still in progress counts as age 0 and the most recently completed window as age 1. With 10 ms windows this covers reference behaviour 30 to 60 ms before entry. Recovery to Normal needs a run of consecutive clean windows. On that recovery a one-cycle phase-realignment enable can be raised, and a configuration input selects whether it is. A downstream loop uses this enable to keep the present phase offset instead of pulling it back to zero.

Top module: `ref_impair_mon`

## Requirements
- R1: While reset is low and after it is released, `holdover` is 1, `freq_word` is 0 and `realign_en` is 0 until eight windows have completed. At the end of the eighth window the block goes to Normal if the last two windows were clean, and otherwise to Holdover.
- R2: A window whose edge count lies outside the band from `cap_lo` to `cap_hi`, both limits inclusive, is impaired and moves Normal to Holdover. `cap_lo`, `cap_hi` and `ref_period` are captured only while reset is low, and later changes to them have no effect.
- R3: A window whose count differs from the previous window's count by more than STEP_MAX is impaired, even when it lies inside the band.
- R4: If no reference rising edge is seen for `ref_period` + 4 system-clock cycles, this loss of signal moves the block to Holdover at once, without waiting for the end of the window.
- R5: On entry to Holdover, `freq_word` becomes the floor of the mean of the counts of the windows aged 3, 4 and 5. The window in progress is age 0 and the most recently completed window is age 1.
- R6: From Holdover, the block returns to Normal only after two consecutive clean windows. A single clean window leaves it in Holdover.
- R7: `realign_en` is a one-cycle pulse. It is raised on a Holdover-to-Normal transition only when `realign_cfg` is 1, and never when `realign_cfg` is 0 or when leaving the startup fill.
- R8: `freq_word` does not change for as long as the block stays in Holdover.
- R9: In Normal, `freq_word` equals the edge count of the most recently completed window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_clk_in | input | 1 | Reference clock, asynchronous to `clk` |
| cap_lo | input | CNT_W | Lower band limit in edges per window, captured during reset |
| cap_hi | input | CNT_W | Upper band limit in edges per window, captured during reset |
| ref_period | input | PER_W | Expected reference period in `clk` cycles, captured during reset |
| realign_cfg | input | 1 | 1 enables phase realignment on recovery |
| holdover | output | 1 | 1 while in Holdover or in the startup fill |
| freq_word | output | CNT_W | Live count in Normal, frozen average in Holdover |
| realign_en | output | 1 | One-cycle realignment pulse on recovery |

## Verification
A window verdict reaches the outputs two cycles after the last cycle of the window, once the synchronised edge count has been registered and then judged. A loss of signal reaches `holdover` one cycle after the gap counter reaches its limit, which is about three cycles of synchronisation after the missing edge was due. The bench places every reference edge at least ten cycles away from a window boundary, so each window's count is exact regardless of synchroniser latency. Its scoreboard items are then sampled at mid-window, or more than twenty cycles after the predicted loss-of-signal point, well clear of every transition.

// File: rtl/rim_pkg.sv
// Shared types for the reference impairment monitor.
package rim_pkg;
    typedef enum logic [1:0] {
        MODE_FILL   = 2'd0,
        MODE_NORMAL = 2'd1,
        MODE_HOLD   = 2'd2
    } rim_mode_e;
endpackage

// File: rtl/rim_edge_sense.sv
// Synchronises the asynchronous reference, finds its rising edges and
// flags loss of signal once the edge gap reaches the period plus a margin.
// Assumes each reference high and low phase lasts at least one clk cycle.
module rim_edge_sense #(
    parameter int SYNC_STAGES = 2,
    parameter int PER_W       = 16,
    parameter int LOS_MARGIN  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic [PER_W-1:0] per_lim,
    output logic             ref_edge,
    output logic             los_level
);
    localparam int GAP_W = PER_W + 1;

    logic [SYNC_STAGES:0] sync_q;
    logic [GAP_W-1:0]     gap_q;
    logic [GAP_W-1:0]     gap_limit;

    assign gap_limit = {1'b0, per_lim} + GAP_W'(LOS_MARGIN);
    assign ref_edge  = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign los_level = (gap_q == gap_limit);

    // Purpose: shift the reference through the synchroniser plus one delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], ref_in};
    end

    // Purpose: count cycles since the last edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gap_q <= '0;
        else if (ref_edge)          gap_q <= '0;
        else if (gap_q != gap_limit) gap_q <= gap_q + 1'b1;
    end

    assert_edge_clears_los_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge |=> !los_level);
endmodule

// File: rtl/rim_window.sv
// Counts reference edges over windows of fixed length and reports, one cycle
// after each window closes, its count and whether loss of signal occurred.
module rim_window #(
    parameter int WIN_CYCLES = 1250000,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge,
    input  logic             los_level,
    output logic             done_q,
    output logic [CNT_W-1:0] count_q,
    output logic             los_q
);
    localparam int WIN_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;

    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] edge_cnt_q;
    logic             los_flag_q;
    logic             win_last;

    assign win_last = (win_q == WIN_W'(WIN_CYCLES - 1));

    // Purpose: step the window position and wrap at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n)        win_q <= '0;
        else if (win_last) win_q <= '0;
        else               win_q <= win_q + 1'b1;
    end

    // Purpose: accumulate edges and loss flags, hand them off at window close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
            los_flag_q <= 1'b0;
            done_q     <= 1'b0;
            count_q    <= '0;
            los_q      <= 1'b0;
        end else begin
            done_q <= win_last;
            if (win_last) begin
                count_q    <= edge_cnt_q + CNT_W'(ref_edge);
                los_q      <= los_flag_q | los_level;
                edge_cnt_q <= '0;
                los_flag_q <= 1'b0;
            end else begin
                edge_cnt_q <= edge_cnt_q + CNT_W'(ref_edge);
                los_flag_q <= los_flag_q | los_level;
            end
        end
    end

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/rim_history.sv
// Circular store of completed window counts. Exposes the newest entry, the
// fill level and the floor mean of the entries at the configured ages.
// Age 1 is the newest stored entry; AGE_HI must not exceed DEPTH.
module rim_history #(
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 16,
    parameter int AGE_LO = 3,
    parameter int AGE_HI = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [CNT_W-1:0]           wr_data,
    output logic [CNT_W-1:0]           newest,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    output logic [CNT_W-1:0]           aged_avg
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int NAGE  = AGE_HI - AGE_LO + 1;
    localparam int SUM_W = CNT_W + $clog2(NAGE + 1);

    logic [CNT_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_nxt;
    logic [SUM_W-1:0] age_sum;

    assign ptr_nxt = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    assign newest  = mem_q[ptr_q];

    // Purpose: advance the write pointer and the saturating fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= PTR_W'(DEPTH - 1);
            fill  <= '0;
        end else if (wr_en) begin
            ptr_q <= ptr_nxt;
            if (fill != FILL_W'(DEPTH)) fill <= fill + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Purpose: store the new count into this slot when it is next in turn.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 mem_q[g] <= '0;
            else if (wr_en && ptr_nxt == PTR_W'(g))     mem_q[g] <= wr_data;
        end
    end

    // Purpose: sum the entries at ages AGE_LO..AGE_HI, then take the floor mean.
    always_comb begin
        age_sum = '0;
        for (int a = AGE_LO; a <= AGE_HI; a++) begin
            age_sum = age_sum + SUM_W'(mem_q[PTR_W'((int'(ptr_q) + DEPTH - (a - 1)) % DEPTH)]);
        end
    end
    assign aged_avg = CNT_W'(age_sum / SUM_W'(NAGE));

    assert_fill_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));
    assert_fill_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill != FILL_W'(DEPTH)) |=> (fill == $past(fill) + 1'b1));
endmodule

// File: rtl/rim_mode_ctrl.sv
// Judges each finished window, runs the Fill/Normal/Holdover mode machine,
// freezes the aged average on Holdover entry and issues the realign pulse.
module rim_mode_ctrl
    import rim_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int CNT_W       = 16,
    parameter int STEP_MAX    = 64,
    parameter int RELOCK_WINS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       done,
    input  logic [CNT_W-1:0]           win_count,
    input  logic                       win_los,
    input  logic                       los_level,
    input  logic [CNT_W-1:0]           lim_lo,
    input  logic [CNT_W-1:0]           lim_hi,
    input  logic [CNT_W-1:0]           prev_count,
    input  logic [$clog2(DEPTH+1)-1:0] fill,
    input  logic [CNT_W-1:0]           aged_avg,
    input  logic                       realign_cfg,
    output logic                       holdover,
    output logic [CNT_W-1:0]           freq_word,
    output logic                       realign_en
);
    localparam int RUN_W  = $clog2(RELOCK_WINS + 1);
    localparam int FILL_W = $clog2(DEPTH + 1);

    rim_mode_e        mode_q;
    logic [CNT_W-1:0] frozen_q;
    logic [RUN_W-1:0] run_q;
    logic [CNT_W-1:0] step_abs;
    logic             win_good;
    logic             run_done;

    assign step_abs = (win_count >= prev_count) ? win_count - prev_count
                                                : prev_count - win_count;
    assign win_good = (win_count >= lim_lo) && (win_count <= lim_hi) && !win_los &&
                      ((fill == '0) || (step_abs <= CNT_W'(STEP_MAX)));
    assign run_done = win_good && !los_level && (run_q >= RUN_W'(RELOCK_WINS - 1));

    assign holdover  = (mode_q != MODE_NORMAL);
    assign freq_word = (mode_q == MODE_NORMAL) ? prev_count : frozen_q;

    // Purpose: count consecutive clean windows, cleared by any impairment.
    always_ff @(posedge clk) begin
        if (!rst_n)                                run_q <= '0;
        else if (los_level || (done && !win_good)) run_q <= '0;
        else if (done && run_q != RUN_W'(RELOCK_WINS)) run_q <= run_q + 1'b1;
    end

    // Purpose: move between modes, freezing the aged average on Holdover entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_FILL;
            frozen_q   <= '0;
            realign_en <= 1'b0;
        end else begin
            realign_en <= 1'b0;
            case (mode_q)
                MODE_FILL: if (done && fill == FILL_W'(DEPTH - 1)) begin
                    if (run_done) mode_q <= MODE_NORMAL;
                    else begin
                        mode_q   <= MODE_HOLD;
                        frozen_q <= aged_avg;
                    end
                end
                MODE_NORMAL: if (los_level || (done && !win_good)) begin
                    mode_q   <= MODE_HOLD;
                    frozen_q <= aged_avg;
                end
                MODE_HOLD: if (done && run_done) begin
                    mode_q     <= MODE_NORMAL;
                    realign_en <= realign_cfg;
                end
                default: mode_q <= MODE_FILL;
            endcase
        end
    end

    assert_realign_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        realign_en |=> !realign_en);
    assert_realign_needs_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        realign_en |-> ($past(realign_cfg) && $past(mode_q == MODE_HOLD)));
    assert_frozen_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD && $past(mode_q == MODE_HOLD)) |-> $stable(freq_word));
    assert_los_enters_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (los_level && mode_q != MODE_FILL) |=> (mode_q == MODE_HOLD));
    assert_fill_not_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FILL) |-> (fill < FILL_W'(DEPTH)));
endmodule

// File: rtl/ref_impair_mon.sv
// Top of the reference impairment monitor. Captures band limits and the
// expected reference period during reset, then wires edge sensing, window
// counting, history and the mode controller together.
module ref_impair_mon #(
    parameter int WIN_CYCLES  = 1250000,
    parameter int CNT_W       = 16,
    parameter int PER_W       = 16,
    parameter int DEPTH       = 8,
    parameter int AGE_LO      = 3,
    parameter int AGE_HI      = 5,
    parameter int STEP_MAX    = 64,
    parameter int RELOCK_WINS = 2,
    parameter int LOS_MARGIN  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_in,
    input  logic [CNT_W-1:0] cap_lo,
    input  logic [CNT_W-1:0] cap_hi,
    input  logic [PER_W-1:0] ref_period,
    input  logic             realign_cfg,
    output logic             holdover,
    output logic [CNT_W-1:0] freq_word,
    output logic             realign_en
);
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  lo_q, hi_q;
    logic [PER_W-1:0]  per_q;
    logic              ref_edge, los_level;
    logic              done, win_los;
    logic [CNT_W-1:0]  win_count, newest, aged_avg;
    logic [FILL_W-1:0] fill;

    // Purpose: hold the configuration inputs as they stood during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= cap_lo;
            hi_q  <= cap_hi;
            per_q <= ref_period;
        end
    end

    rim_edge_sense #(.SYNC_STAGES(SYNC_STAGES), .PER_W(PER_W), .LOS_MARGIN(LOS_MARGIN)) u_edge (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_clk_in), .per_lim(per_q),
        .ref_edge(ref_edge), .los_level(los_level));

    rim_window #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .los_level(los_level),
        .done_q(done), .count_q(win_count), .los_q(win_los));

    rim_history #(.DEPTH(DEPTH), .CNT_W(CNT_W), .AGE_LO(AGE_LO), .AGE_HI(AGE_HI)) u_hist (
        .clk(clk), .rst_n(rst_n), .wr_en(done), .wr_data(win_count),
        .newest(newest), .fill(fill), .aged_avg(aged_avg));

    rim_mode_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .STEP_MAX(STEP_MAX),
                    .RELOCK_WINS(RELOCK_WINS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .done(done), .win_count(win_count), .win_los(win_los),
        .los_level(los_level), .lim_lo(lo_q), .lim_hi(hi_q), .prev_count(newest),
        .fill(fill), .aged_avg(aged_avg), .realign_cfg(realign_cfg),
        .holdover(holdover), .freq_word(freq_word), .realign_en(realign_en));

    assert_normal_in_band_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!holdover && $past(!holdover)) |-> (freq_word >= lo_q && freq_word <= hi_q));
endmodule

// File: tb/tb_ref_impair_mon.sv
// Scoreboard bench: the driver task queues expected results, a monitor pops
// them at their due cycle and compares them with the design outputs.
module tb_ref_impair_mon;
    localparam int WIN = 200;
    localparam int CW  = 12;
    localparam int PW  = 10;

    typedef struct {
        int    due;
        bit    hold;
        int    freq;
        int    rcnt;
        string tag;
    } exp_t;

    logic          clk = 0, rst_n = 0, ref_clk_in = 0, realign_cfg = 1;
    logic [CW-1:0] cap_lo = 8, cap_hi = 30;
    logic [PW-1:0] ref_period = 60;
    logic          holdover, realign_en;
    logic [CW-1:0] freq_word;

    int   tests = 0, fails = 0, cyc = 0, rcount = 0;
    bit   done_flag = 0;
    int   n_of [40];
    int   stop_of [40];
    exp_t sb_q [$];

    always #4 clk = ~clk;

    ref_impair_mon #(.WIN_CYCLES(WIN), .CNT_W(CW), .PER_W(PW), .STEP_MAX(10)) dut (
        .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .cap_lo(cap_lo),
        .cap_hi(cap_hi), .ref_period(ref_period), .realign_cfg(realign_cfg),
        .holdover(holdover), .freq_word(freq_word), .realign_en(realign_en));

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Reference generator: n edges per window from offset 10, spacing 180/n.
    always @(negedge clk) begin
        int w, off, s;
        w   = cyc / WIN;
        off = cyc % WIN;
        ref_clk_in <= 1'b0;
        if (rst_n && w < 40 && n_of[w] > 0) begin
            s = 180 / n_of[w];
            if (off >= 10 && off <= stop_of[w] && ((off - 10) % s) < 2 &&
                ((off - 10) / s) < n_of[w])
                ref_clk_in <= 1'b1;
        end
    end

    always @(negedge clk) if (rst_n && realign_en) rcount++;

    task automatic check(input string tag, input bit ok, input string detail);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", tag, detail);
        end
    endtask

    task automatic expect_at(input int w, input int off, input bit hold, input int freq,
                             input int rc, input string tag);
        exp_t e;
        e.due = w * WIN + off; e.hold = hold; e.freq = freq; e.rcnt = rc; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Monitor: pop each item and compare at its due cycle.
    initial begin
        exp_t e;
        wait (rst_n);
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            while (cyc < e.due) @(negedge clk);
            check(e.tag, holdover == e.hold && int'(freq_word) == e.freq && rcount == e.rcnt,
                  $sformatf("actual hold=%0d freq=%0d realign=%0d expected hold=%0d freq=%0d realign=%0d",
                            holdover, freq_word, rcount, e.hold, e.freq, e.rcnt));
        end
        finish_run();
    end

    // Driver: window schedule, configuration changes and expectations.
    initial begin
        for (int i = 0; i < 40; i++) begin n_of[i] = 20; stop_of[i] = WIN; end
        for (int i = 11; i <= 14; i++) n_of[i] = 16;
        n_of[15] = 7;  n_of[16] = 16; n_of[17] = 16; n_of[18] = 16; n_of[19] = 16;
        n_of[20] = 28; n_of[21] = 28; n_of[22] = 28; n_of[23] = 30; n_of[24] = 22;
        n_of[25] = 30; stop_of[25] = 95; n_of[26] = 0;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 reset", holdover == 1 && freq_word == 0 && realign_en == 0,
              $sformatf("actual hold=%0d freq=%0d rl=%0d expected 1 0 0", holdover, freq_word, realign_en));
        expect_at(1, 100, 1, 0, 0, "R1 fill");
        expect_at(7, 100, 1, 0, 0, "R1 fill end");
        expect_at(8, 100, 0, 20, 0, "R1 R9 R2 normal after fill, limits ignored");
        expect_at(12, 100, 0, 16, 0, "R9 live count");
        expect_at(16, 100, 1, 17, 0, "R2 R5 out of band, aged mean");
        expect_at(17, 100, 1, 17, 0, "R6 one clean window stays");
        expect_at(18, 100, 0, 16, 1, "R6 R7 recovery with realign");
        expect_at(21, 100, 1, 13, 1, "R3 R5 step impairment");
        expect_at(23, 100, 0, 28, 1, "R7 no realign when cfg 0");
        expect_at(24, 100, 0, 30, 1, "R2 upper limit inclusive");
        expect_at(25, 50, 0, 22, 1, "R9 before loss");
        expect_at(25, 185, 1, 28, 1, "R4 R5 loss of signal mid window");
        expect_at(27, 100, 1, 28, 1, "R8 frozen held");
        expect_at(29, 100, 1, 28, 1, "R8 R6 frozen held");
        expect_at(30, 100, 0, 20, 2, "R7 R9 recovery after loss");
        @(negedge clk); rst_n = 1;
        // R2: band limit and period changes after reset must be ignored.
        wait (cyc == 3 * WIN); @(negedge clk);
        cap_lo = 50; cap_hi = 9; ref_period = 5;
        wait (cyc == 20 * WIN); @(negedge clk); realign_cfg = 0;
        wait (cyc == 25 * WIN); @(negedge clk); realign_cfg = 1;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule